// File: doc/BRIEF.md
# Four-Channel Shadowed PWM Generator

The block produces a pulse-width modulated waveform on each of several channels. A simple word-addressed register port sets up each channel: a period length and a level-count, both in clock cycles. Further registers hold the run, polarity, update and drive-enable controls, each as a bitmask with one bit per channel. The waveform hardware never reads the programmable registers directly. It runs from shadow copies, and these are loaded only when a channel starts or when software asks for a live update.

Each running channel counts from 0 up to period−1 and then wraps. While the count is below the level-count, the output holds the "counted" level. That level is low when the channel's polarity bit is clear and high when it is set. For the rest of the period the output holds the opposite level. A channel that is not running drives low. The drive-enable bit decides whether the pin is actively driven (output mode) or left undriven (input mode).

To retune a running channel, software writes the new period and level-count, then writes 1 and then 0 to that channel's update bit. The values present at the 1-to-0 step are staged. They take effect at the next wrap, so no period is ever cut short.

Top module: `pwm_multi`

## Requirements
- R1: After reset, reads return 2 for every period register, 1 for every level-count register, and 0 for the polarity, run, flag, update and drive-enable masks. A read returns data one clock after the address is presented.
- R2: Channel n's level-count register is at byte offset 8·n and its period register at 8·n+4. The polarity mask is at 0x40, run at 0x44, flag at 0x48 (plain read/write storage), update at 0x4C and drive-enable at 0xD0. Bit n of each mask belongs to channel n. Unmapped offsets read 0.
- R3: A 0-to-1 change of a channel's run bit loads the current period and level-count into its shadows and restarts its count at 0. The first output cycle of the new waveform appears two clocks after the write edge.
- R4: A channel whose run bit is 0 drives pwm_out low.
- R5: With period P and level-count H (0 < H < P), each period is H cycles at the counted level followed by P−H cycles at the opposite level. The counted level is low when the polarity bit is 0 and high when it is 1.
- R6: A level-count of 0 gives the opposite level for the whole period, which is constant high at polarity 0. A level-count at or above the period gives the counted level for the whole period.
- R7: Period or level-count writes to a running channel do not change its waveform until an update pulse is given.
- R8: A 1-then-0 sequence on a running channel's update bit stages the register values present at the 0 write. The staged values become the shadows at the next wrap of the count.
- R9: Period and level-count registers keep only their low 30 bits. A period below 2 runs as 2.
- R10: pwm_oe reflects the drive-enable mask (1 = driven output, 0 = undriven input). A polarity change acts on a running channel without an update pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for bus_addr |
| pwm_out | output | 4 | Waveform level per channel |
| pwm_oe | output | 4 | Per-channel pin drive enable |

## Verification
The bench builds the block with its default parameters: four channels, 30-bit counts, an 8-bit address and a 32-bit data word. With these, every mask bit and the 0xD0 drive-enable word are in reach, and the 30-bit truncation shows on readback of an all-ones write. The bench programs periods of only a few cycles, so wraps, the minimum-period clamp, a level-count above the period, and an update pulse landing mid-period all happen within a short run. The behavioural model is compared on every clock on all four channels at once.

// File: rtl/pwm_multi_pkg.sv
package pwm_multi_pkg;
  // Byte offsets of the shared per-channel mask words
  localparam int unsigned OFF_POL   = 32'h40;
  localparam int unsigned OFF_RUN   = 32'h44;
  localparam int unsigned OFF_FLAG  = 32'h48;
  localparam int unsigned OFF_UPD   = 32'h4C;
  localparam int unsigned OFF_OE    = 32'hD0;
  // Per-channel register pair spacing and layout
  localparam int unsigned CH_STRIDE = 8;
  localparam int unsigned CH_PER    = 4;
  // Reset values of the per-channel count registers
  localparam int unsigned RST_PER   = 2;
  localparam int unsigned RST_LVL   = 1;
endpackage

// File: rtl/pwm_multi_regs.sv
module pwm_multi_regs
  import pwm_multi_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CW  = 30,
  parameter int AW  = 8,
  parameter int DW  = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [CW-1:0] per_o [NCH],
  output logic [CW-1:0] lvl_o [NCH],
  output logic [NCH-1:0] pol_o,
  output logic [NCH-1:0] run_o,
  output logic [NCH-1:0] upd_o,
  output logic [NCH-1:0] oe_o
);
  logic [NCH-1:0] flag_q;
  logic [DW-1:0]  rmux;
  logic           unused_hi;

  assign unused_hi = ^wdata[DW-1:CW];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCH; i++) begin
        per_o[i] <= CW'(RST_PER);
        lvl_o[i] <= CW'(RST_LVL);
      end
      pol_o  <= '0;
      run_o  <= '0;
      upd_o  <= '0;
      oe_o   <= '0;
      flag_q <= '0;
    end else if (we) begin
      for (int i = 0; i < NCH; i++) begin
        if (addr == AW'(CH_STRIDE * i))          lvl_o[i] <= wdata[CW-1:0];
        if (addr == AW'(CH_STRIDE * i + CH_PER)) per_o[i] <= wdata[CW-1:0];
      end
      if (addr == AW'(OFF_POL))  pol_o  <= wdata[NCH-1:0];
      if (addr == AW'(OFF_RUN))  run_o  <= wdata[NCH-1:0];
      if (addr == AW'(OFF_FLAG)) flag_q <= wdata[NCH-1:0];
      if (addr == AW'(OFF_UPD))  upd_o  <= wdata[NCH-1:0];
      if (addr == AW'(OFF_OE))   oe_o   <= wdata[NCH-1:0];
    end
  end

  always_comb begin
    rmux = '0;
    for (int i = 0; i < NCH; i++) begin
      if (addr == AW'(CH_STRIDE * i))          rmux = DW'(lvl_o[i]);
      if (addr == AW'(CH_STRIDE * i + CH_PER)) rmux = DW'(per_o[i]);
    end
    if (addr == AW'(OFF_POL))  rmux = DW'(pol_o);
    if (addr == AW'(OFF_RUN))  rmux = DW'(run_o);
    if (addr == AW'(OFF_FLAG)) rmux = DW'(flag_q);
    if (addr == AW'(OFF_UPD))  rmux = DW'(upd_o);
    if (addr == AW'(OFF_OE))   rmux = DW'(oe_o);
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rmux;
  end

  // R10
  oe_write_chk: assert property (@(posedge clk) disable iff (rst)
    (we && addr == AW'(OFF_OE)) |=> (oe_o == $past(wdata[NCH-1:0])));

  // R2
  run_write_chk: assert property (@(posedge clk) disable iff (rst)
    (we && addr == AW'(OFF_RUN)) |=> (run_o == $past(wdata[NCH-1:0])));
endmodule

// File: rtl/pwm_multi_chan.sv
module pwm_multi_chan #(
  parameter int CW = 30
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run_i,
  input  logic          upd_i,
  input  logic          pol_i,
  input  logic [CW-1:0] per_i,
  input  logic [CW-1:0] lvl_i,
  output logic          pwm_o
);
  localparam logic [CW-1:0] MIN_PER = CW'(2);

  logic          active, pend, upd_d;
  logic [CW-1:0] cnt, sh_per, sh_lvl, stg_per, stg_lvl;
  logic [CW-1:0] per_eff, lvl_eff;
  logic          wrap, upd_fall, level;

  // Clamp the programmed values before they enter a shadow
  assign per_eff  = (per_i < MIN_PER) ? MIN_PER : per_i;
  assign lvl_eff  = (lvl_i > per_eff) ? per_eff : lvl_i;
  assign wrap     = (cnt >= sh_per - CW'(1));
  assign upd_fall = upd_d & ~upd_i;
  assign level    = (cnt < sh_lvl) ? pol_i : ~pol_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      pend    <= 1'b0;
      upd_d   <= 1'b0;
      cnt     <= '0;
      sh_per  <= MIN_PER;
      sh_lvl  <= CW'(1);
      stg_per <= MIN_PER;
      stg_lvl <= CW'(1);
      pwm_o   <= 1'b0;
    end else begin
      upd_d <= upd_i;
      pwm_o <= active & level;
      if (!run_i) begin
        active <= 1'b0;
        pend   <= 1'b0;
        cnt    <= '0;
      end else if (!active) begin
        active <= 1'b1;
        pend   <= 1'b0;
        cnt    <= '0;
        sh_per <= per_eff;
        sh_lvl <= lvl_eff;
      end else begin
        if (wrap) begin
          cnt <= '0;
          if (pend) begin
            sh_per <= stg_per;
            sh_lvl <= stg_lvl;
            pend   <= 1'b0;
          end
        end else begin
          cnt <= cnt + CW'(1);
        end
        if (upd_fall) begin
          stg_per <= per_eff;
          stg_lvl <= lvl_eff;
          pend    <= 1'b1;
        end
      end
    end
  end

  // R5
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    active |-> (cnt < sh_per));

  // R4
  idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    !active |=> !pwm_o);

  // R6
  lvl_bound_chk: assert property (@(posedge clk) disable iff (rst)
    sh_lvl <= sh_per);

  // R7
  shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (active && cnt != '0) |-> ($stable(sh_per) && $stable(sh_lvl)));

  // R9
  per_min_chk: assert property (@(posedge clk) disable iff (rst)
    active |-> (sh_per >= MIN_PER));
endmodule

// File: rtl/pwm_multi.sv
module pwm_multi #(
  parameter int NCH = 4,
  parameter int CW  = 30,
  parameter int AW  = 8,
  parameter int DW  = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           bus_we,
  input  logic [AW-1:0]  bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  output logic [NCH-1:0] pwm_out,
  output logic [NCH-1:0] pwm_oe
);
  logic [CW-1:0]  per_a [NCH];
  logic [CW-1:0]  lvl_a [NCH];
  logic [NCH-1:0] pol, run, upd;

  pwm_multi_regs #(.NCH(NCH), .CW(CW), .AW(AW), .DW(DW)) u_regs (
    .clk   (clk),
    .rst   (rst),
    .we    (bus_we),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .rdata (bus_rdata),
    .per_o (per_a),
    .lvl_o (lvl_a),
    .pol_o (pol),
    .run_o (run),
    .upd_o (upd),
    .oe_o  (pwm_oe)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pwm_multi_chan #(.CW(CW)) u_ch (
      .clk   (clk),
      .rst   (rst),
      .run_i (run[g]),
      .upd_i (upd[g]),
      .pol_i (pol[g]),
      .per_i (per_a[g]),
      .lvl_i (lvl_a[g]),
      .pwm_o (pwm_out[g])
    );
  end
endmodule

// File: tb/test_pwm_multi.sv
module test_pwm_multi;
  localparam longint MASK = 64'h3FFF_FFFF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  pwm_out, pwm_oe;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  bit cmp_en = 0;
  string cur_req = "R1";

  pwm_multi i_pwm_multi (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwm_out(pwm_out), .pwm_oe(pwm_oe)
  );

  always #10 clk = ~clk;

  // Behavioural model state
  longint m_per[4], m_lvl[4];
  bit [3:0] m_pol, m_run, m_upd, m_oe, m_flag;
  bit       a_on[4], a_pend[4], a_ud[4];
  longint   a_cnt[4], a_p[4], a_l[4], a_sp[4], a_sl[4];
  bit [3:0] exp_out;

  function automatic longint eff_per(longint p);
    return (p < 2) ? 2 : p;
  endfunction
  function automatic longint eff_lvl(longint l, longint p);
    return (l > eff_per(p)) ? eff_per(p) : l;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < 4; c++) begin
        m_per[c] = 2; m_lvl[c] = 1;
        a_on[c] = 0; a_pend[c] = 0; a_ud[c] = 0; a_cnt[c] = 0;
        a_p[c] = 2; a_l[c] = 1; a_sp[c] = 2; a_sl[c] = 1;
      end
      m_pol = 0; m_run = 0; m_upd = 0; m_oe = 0; m_flag = 0; exp_out = 0;
    end else begin
      for (int c = 0; c < 4; c++) begin
        bit fall;
        exp_out[c] = a_on[c] ? ((a_cnt[c] < a_l[c]) ? m_pol[c] : !m_pol[c]) : 1'b0;
        fall = a_ud[c] && !m_upd[c];
        a_ud[c] = m_upd[c];
        if (!m_run[c]) begin
          a_on[c] = 0; a_pend[c] = 0; a_cnt[c] = 0;
        end else if (!a_on[c]) begin
          a_on[c] = 1; a_pend[c] = 0; a_cnt[c] = 0;
          a_p[c] = eff_per(m_per[c]); a_l[c] = eff_lvl(m_lvl[c], m_per[c]);
        end else begin
          if (a_cnt[c] >= a_p[c] - 1) begin
            a_cnt[c] = 0;
            if (a_pend[c]) begin a_p[c] = a_sp[c]; a_l[c] = a_sl[c]; a_pend[c] = 0; end
          end else a_cnt[c]++;
          if (fall) begin
            a_sp[c] = eff_per(m_per[c]); a_sl[c] = eff_lvl(m_lvl[c], m_per[c]);
            a_pend[c] = 1;
          end
        end
      end
      if (bus_we) begin
        for (int c = 0; c < 4; c++) begin
          if (bus_addr == 8'(8 * c))     m_lvl[c] = longint'(bus_wdata) & MASK;
          if (bus_addr == 8'(8 * c + 4)) m_per[c] = longint'(bus_wdata) & MASK;
        end
        case (bus_addr)
          8'h40: m_pol  = bus_wdata[3:0];
          8'h44: m_run  = bus_wdata[3:0];
          8'h48: m_flag = bus_wdata[3:0];
          8'h4C: m_upd  = bus_wdata[3:0];
          8'hD0: m_oe   = bus_wdata[3:0];
          default: ;
        endcase
      end
    end
  end

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (cmp_en && !rst) begin
      checks++;
      if (pwm_out !== exp_out || pwm_oe !== m_oe) begin
        failures++;
        $display("FAIL %s cycle compare: out=%b oe=%b expected out=%b oe=%b",
                 cur_req, pwm_out, pwm_oe, exp_out, m_oe);
      end
    end
  end

  task automatic check(string tag, longint got, longint exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic [7:0] a, longint exp);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    check(tag, longint'(bus_rdata), exp);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_high(string tag, int ch, int win, int exp);
    int hi = 0;
    for (int k = 0; k < win; k++) begin
      @(negedge clk);
      if (pwm_out[ch]) hi++;
    end
    check(tag, hi, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    cmp_en = 1;

    cur_req = "R1";
    check("R1 reset out", pwm_out, 0);
    rd_chk("R1 lvl0 reset", 8'h00, 1);
    rd_chk("R1 per0 reset", 8'h04, 2);
    rd_chk("R1 per3 reset", 8'h1C, 2);
    rd_chk("R1 pol reset", 8'h40, 0);
    rd_chk("R1 run reset", 8'h44, 0);
    rd_chk("R1 upd reset", 8'h4C, 0);
    rd_chk("R1 oe reset", 8'hD0, 0);

    cur_req = "R2";
    rd_chk("R2 unmapped", 8'h80, 0);
    wr(8'h48, 32'hA);
    rd_chk("R2 flag rw", 8'h48, 32'hA);
    wr(8'h10, 32'd9);
    rd_chk("R2 lvl2 offset", 8'h10, 9);
    rd_chk("R2 per2 untouched", 8'h14, 2);

    cur_req = "R9";
    wr(8'h0C, 32'hFFFF_FFFF);
    rd_chk("R9 per1 truncated", 8'h0C, 32'h3FFF_FFFF);

    cur_req = "R10";
    wr(8'hD0, 32'hF);
    check("R10 oe out", pwm_oe, 4'hF);

    // Channel programming
    cur_req = "R3";
    wr(8'h00, 2);  wr(8'h04, 5);   // ch0: P=5 H=2
    wr(8'h08, 0);  wr(8'h0C, 4);   // ch1: P=4 H=0
    wr(8'h10, 7);  wr(8'h14, 3);   // ch2: P=3 H=7, polarity 1
    wr(8'h18, 1);  wr(8'h1C, 1);   // ch3: P=1 -> 2, H=1
    wr(8'h40, 32'h4);
    wr(8'h44, 32'h1);
    check("R3 ch0 low right after start", pwm_out[0], 0);
    idle(12);
    wr(8'h44, 32'hF);
    idle(6);

    cur_req = "R5";
    count_high("R5 ch0 P5 H2 high count", 0, 10, 6);
    cur_req = "R6";
    count_high("R6 ch1 H0 constant high", 1, 8, 8);
    count_high("R6 ch2 H>P counted level", 2, 6, 6);
    cur_req = "R9";
    count_high("R9 ch3 period clamp", 3, 8, 4);

    cur_req = "R7";
    wr(8'h04, 8);  wr(8'h00, 6);
    idle(3);
    count_high("R7 ch0 unchanged before update", 0, 10, 6);

    cur_req = "R8";
    wr(8'h4C, 32'h1);
    wr(8'h4C, 32'h0);
    idle(10);
    count_high("R8 ch0 new period after update", 0, 16, 4);

    cur_req = "R10";
    wr(8'h40, 32'h5);
    idle(10);
    count_high("R10 ch0 live polarity", 0, 16, 12);

    cur_req = "R4";
    wr(8'h44, 32'hD);
    idle(2);
    count_high("R4 ch1 stopped low", 1, 8, 0);

    cur_req = "R3";
    wr(8'h08, 1);
    wr(8'h44, 32'hF);
    idle(4);
    count_high("R3 ch1 restart new level", 1, 8, 6);

    cur_req = "R4";
    wr(8'h44, 32'h0);
    idle(3);
    check("R4 all stopped", pwm_out, 0);
    wr(8'hD0, 32'h0);
    check("R10 oe cleared", pwm_oe, 0);
    idle(4);

    cmp_en = 0;
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule